// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Banks

This unit is the interrupt half of a general-purpose pin port. Each pin's already-synchronised level is compared with its level on the previous clock. A rising or falling transition raises a sticky flag for that pin, but only if that pin's detector for the direction is armed. Software arms and disarms the detectors by writing ones to separate "on" and "off" words, so it never has to read, modify and write a mask. It clears flags by writing ones to the flag word.

Flags are grouped into banks of sixteen pins, and each bank drives one level-sensitive interrupt line. Every 32-pin register set feeds two banks: its low half-word feeds the even bank and its high half-word feeds the odd bank. A single bank-enable word gates each line. The gate does not stop flags from latching. The number of register sets is a parameter. The bus is a simple single-cycle write strobe with a combinational read.

Top module: `gpei_top`

## Requirements
- R1: Writing ones to a set's rise-on word (set base + 0x00) arms rising detection for those pins. Writing ones to its fall-on word (base + 0x08) arms falling detection. Zero bits leave the arm state unchanged.
- R2: Writing ones to the rise-off word (base + 0x04) or the fall-off word (base + 0x0C) disarms that direction for those pins. Zero bits have no effect.
- R3: A transition is a pin level that differs from the pin's level on the previous clock. A pin's flag is raised on a rising transition if rising is armed, on a falling transition if falling is armed, and on either if both are armed. Unarmed transitions never raise a flag. The flag is visible one clock after the edge that samples the new level.
- R4: The flag word (base + 0x10) reads the current flags. Writing ones to it clears those flags, and zero bits leave their flags as they were.
- R5: A transition that would raise a flag in the same cycle as a write clearing that flag leaves the flag set.
- R6: Register set s starts at byte 0x10 + 0x20*s and covers pins 32s to 32s+31. Its bits 15:0 feed bank 2s and its bits 31:16 feed bank 2s+1.
- R7: The bank-enable word at byte 0x08 holds one bit per bank, and bit n gates irq_o[n]. It reads back as written. Flags latch whatever its value.
- R8: irq_o[n] stays high while its bank is enabled and any of the bank's sixteen flags is set. It falls once software clears them, and it can rise again on a later transition.
- R9: Reset clears all arm bits, all flags and the bank-enable word, so every irq_o bit is low.
- R10: The rise-on and rise-off words both read the rising arm mask, and the fall-on and fall-off words both read the falling arm mask. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NUM_SETS*32 | Synchronised pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | NUM_SETS*2 | Per-bank interrupt lines |

## Verification
The bench instantiates the block with two register sets, which gives four banks. This is the smallest configuration where the half-word split and the set-to-bank numbering both matter, so a pin in the high half of the second set must light bank 3 and no other bank. It also exercises a pin armed for both directions next to pins armed for one direction only. Further cases cover a flag raised in the very cycle it is cleared and a gated bank whose flags keep latching. A behavioural model tracks every interrupt line on every clock.

// File: rtl/gpei_pkg.sv
package gpei_pkg;

   localparam int unsigned REG_W         = 32;
   localparam int unsigned BANK_W        = 16;
   localparam int unsigned BANKS_PER_SET = REG_W / BANK_W;

   localparam int unsigned OFS_BANK_EN   = 'h08;
   localparam int unsigned SET_BASE      = 'h10;
   localparam int unsigned SET_STRIDE    = 'h20;

   localparam int unsigned OFS_RISE_ON   = 'h00;
   localparam int unsigned OFS_RISE_OFF  = 'h04;
   localparam int unsigned OFS_FALL_ON   = 'h08;
   localparam int unsigned OFS_FALL_OFF  = 'h0C;
   localparam int unsigned OFS_FLAGS     = 'h10;

   typedef struct packed {
      logic rise_on;
      logic rise_off;
      logic fall_on;
      logic fall_off;
      logic flag_clr;
   } set_wr_t;

   typedef enum logic [1:0] {
      RD_NONE,
      RD_RISE,
      RD_FALL,
      RD_FLAGS
   } set_rd_e;

endpackage

// File: rtl/gpei_set_decode.sv
module gpei_set_decode
   import gpei_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned SET_IDX = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output set_wr_t           wr,
   output set_rd_e           rd
);

   localparam int unsigned BASE = SET_BASE + SET_IDX * SET_STRIDE;
   localparam logic [ADDR_W-1:0] A_RISE_ON  = ADDR_W'(BASE + OFS_RISE_ON);
   localparam logic [ADDR_W-1:0] A_RISE_OFF = ADDR_W'(BASE + OFS_RISE_OFF);
   localparam logic [ADDR_W-1:0] A_FALL_ON  = ADDR_W'(BASE + OFS_FALL_ON);
   localparam logic [ADDR_W-1:0] A_FALL_OFF = ADDR_W'(BASE + OFS_FALL_OFF);
   localparam logic [ADDR_W-1:0] A_FLAGS    = ADDR_W'(BASE + OFS_FLAGS);

   always_comb begin
      wr = '0;
      rd = RD_NONE;
      if (addr == A_RISE_ON) begin
         wr.rise_on = we;
         rd = RD_RISE;
      end else if (addr == A_RISE_OFF) begin
         wr.rise_off = we;
         rd = RD_RISE;
      end else if (addr == A_FALL_ON) begin
         wr.fall_on = we;
         rd = RD_FALL;
      end else if (addr == A_FALL_OFF) begin
         wr.fall_off = we;
         rd = RD_FALL;
      end else if (addr == A_FLAGS) begin
         wr.flag_clr = we;
         rd = RD_FLAGS;
      end
   end

endmodule

// File: rtl/gpei_edge_detect.sv
module gpei_edge_detect #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise_ev,
   output logic [W-1:0] fall_ev
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise_ev = lvl & ~prev_q;
   assign fall_ev = ~lvl & prev_q;

endmodule

// File: rtl/gpei_set_core.sv
module gpei_set_core
   import gpei_pkg::*;
#(
   parameter int unsigned W = REG_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  set_wr_t      wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] rise_ev,
   input  logic [W-1:0] fall_ev,
   output logic [W-1:0] rise_en,
   output logic [W-1:0] fall_en,
   output logic [W-1:0] flags
);

   logic [W-1:0] rise_q, fall_q, flags_q;
   logic [W-1:0] hits, clr_mask;

   assign hits     = (rise_ev & rise_q) | (fall_ev & fall_q);
   assign clr_mask = wr.flag_clr ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rise_q  <= '0;
         fall_q  <= '0;
         flags_q <= '0;
      end else begin
         if (wr.rise_on)       rise_q <= rise_q | wdata;
         else if (wr.rise_off) rise_q <= rise_q & ~wdata;
         if (wr.fall_on)       fall_q <= fall_q | wdata;
         else if (wr.fall_off) fall_q <= fall_q & ~wdata;
         flags_q <= (flags_q & ~clr_mask) | hits;
      end
   end

   assign rise_en = rise_q;
   assign fall_en = fall_q;
   assign flags   = flags_q;

endmodule

// File: rtl/gpei_bank_gate.sv
module gpei_bank_gate #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_W    = 16
) (
   input  logic [NUM_BANKS*BANK_W-1:0] flags_flat,
   input  logic [NUM_BANKS-1:0]        bank_en,
   output logic [NUM_BANKS-1:0]        irq
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign irq[b] = bank_en[b] & (|flags_flat[b*BANK_W +: BANK_W]);
   end

endmodule

// File: rtl/gpei_top.sv
module gpei_top
   import gpei_pkg::*;
#(
   parameter int unsigned NUM_SETS = 2,
   parameter int unsigned ADDR_W   = 8,
   localparam int unsigned NUM_PINS  = NUM_SETS * REG_W,
   localparam int unsigned NUM_BANKS = NUM_SETS * BANKS_PER_SET
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PINS-1:0]  pin_lvl,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [REG_W-1:0]     bus_wdata,
   output logic [REG_W-1:0]     bus_rdata,
   output logic [NUM_BANKS-1:0] irq_o
);

   if (NUM_SETS < 1 || NUM_BANKS > REG_W || ADDR_W > 30) begin : g_bad_cfg
      $error("gpei_top: NUM_SETS/ADDR_W out of range");
   end
   if (ADDR_W <= 30 &&
       (SET_BASE + NUM_SETS * SET_STRIDE) > (1 << ADDR_W)) begin : g_bad_map
      $error("gpei_top: register map does not fit ADDR_W");
   end

   localparam logic [ADDR_W-1:0] A_BANK_EN = ADDR_W'(OFS_BANK_EN);

   set_wr_t [NUM_SETS-1:0]           wr_s;
   set_rd_e                          rd_s [NUM_SETS];
   logic [NUM_SETS-1:0][REG_W-1:0]   rise_ev_s, fall_ev_s;
   logic [NUM_SETS-1:0][REG_W-1:0]   rise_en_s, fall_en_s, flags_s;
   logic [NUM_BANKS-1:0]             ben_q;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      gpei_set_decode #(
         .ADDR_W  (ADDR_W),
         .SET_IDX (s)
      ) u_dec (
         .addr (bus_addr),
         .we   (bus_we),
         .wr   (wr_s[s]),
         .rd   (rd_s[s])
      );

      gpei_edge_detect #(
         .W (REG_W)
      ) u_edge (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl     (pin_lvl[s*REG_W +: REG_W]),
         .rise_ev (rise_ev_s[s]),
         .fall_ev (fall_ev_s[s])
      );

      gpei_set_core #(
         .W (REG_W)
      ) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (wr_s[s]),
         .wdata   (bus_wdata),
         .rise_ev (rise_ev_s[s]),
         .fall_ev (fall_ev_s[s]),
         .rise_en (rise_en_s[s]),
         .fall_en (fall_en_s[s]),
         .flags   (flags_s[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                               ben_q <= '0;
      else if (bus_we && bus_addr == A_BANK_EN) ben_q <= bus_wdata[NUM_BANKS-1:0];
   end

   gpei_bank_gate #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_gate (
      .flags_flat (flags_s),
      .bank_en    (ben_q),
      .irq        (irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_BANK_EN) bus_rdata = REG_W'(ben_q);
      for (int s = 0; s < NUM_SETS; s++) begin
         case (rd_s[s])
            RD_RISE:  bus_rdata = rise_en_s[s];
            RD_FALL:  bus_rdata = fall_en_s[s];
            RD_FLAGS: bus_rdata = flags_s[s];
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/gpei_chk.sv
module gpei_chk
   import gpei_pkg::*;
#(
   parameter int unsigned NUM_SETS = 2,
   localparam int unsigned NUM_BANKS = NUM_SETS * BANKS_PER_SET
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [REG_W-1:0]               bus_wdata,
   input set_wr_t [NUM_SETS-1:0]         wr_s,
   input logic [NUM_SETS-1:0][REG_W-1:0] rise_ev_s,
   input logic [NUM_SETS-1:0][REG_W-1:0] fall_ev_s,
   input logic [NUM_SETS-1:0][REG_W-1:0] rise_en_s,
   input logic [NUM_SETS-1:0][REG_W-1:0] fall_en_s,
   input logic [NUM_SETS-1:0][REG_W-1:0] flags_s,
   input logic [NUM_BANKS-1:0]           ben_q,
   input logic [NUM_BANKS-1:0]           irq_o
);

   logic [NUM_BANKS*BANK_W-1:0] flags_flat;
   assign flags_flat = flags_s;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      p_arm_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
         wr_s[s].rise_on |=> ((rise_en_s[s] & $past(bus_wdata)) == $past(bus_wdata)));
      p_arm_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
         wr_s[s].fall_on |=> ((fall_en_s[s] & $past(bus_wdata)) == $past(bus_wdata)));
      p_disarm_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_s[s].rise_off |=> ((rise_en_s[s] & $past(bus_wdata)) == '0));
      p_disarm_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_s[s].fall_off |=> ((fall_en_s[s] & $past(bus_wdata)) == '0));
      p_only_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((flags_s[s] & ~$past(flags_s[s]) &
                    ~$past((rise_ev_s[s] & rise_en_s[s]) | (fall_ev_s[s] & fall_en_s[s]))) == '0));
      p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_s[s].flag_clr |=> ((flags_s[s] & $past(flags_s[s])) == $past(flags_s[s])));
      p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
         wr_s[s].flag_clr |=> ((flags_s[s] & $past(bus_wdata) &
                                ~$past(rise_ev_s[s] | fall_ev_s[s])) == '0));
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !ben_q[b] |-> !irq_o[b]);
      p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ben_q[b] && (|flags_flat[b*BANK_W +: BANK_W])) |-> irq_o[b]);
   end

endmodule

bind gpei_top gpei_chk #(.NUM_SETS(NUM_SETS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wdata (bus_wdata),
   .wr_s      (wr_s),
   .rise_ev_s (rise_ev_s),
   .fall_ev_s (fall_ev_s),
   .rise_en_s (rise_en_s),
   .fall_en_s (fall_en_s),
   .flags_s   (flags_s),
   .ben_q     (ben_q),
   .irq_o     (irq_o)
);

// File: tb/gpei_top_tb_top.sv
module gpei_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 2;
   localparam int NP = NS * 32;
   localparam int NB = NS * 2;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NP-1:0] pin_lvl = '0;
   logic          bus_we = 0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NB-1:0] irq_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   gpei_top #(.NUM_SETS(NS), .ADDR_W(8)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_lvl   (pin_lvl),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   logic [31:0]   m_rise [NS];
   logic [31:0]   m_fall [NS];
   logic [31:0]   m_flag [NS];
   logic [31:0]   m_prev [NS];
   logic [NB-1:0] m_ben;
   int            m_rel, m_set, m_off;
   logic [31:0]   m_pin, m_hit, m_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NS; s++) begin
            m_rise[s] = 0; m_fall[s] = 0; m_flag[s] = 0; m_prev[s] = 0;
         end
         m_ben = 0;
      end else begin
         m_rel = int'(bus_addr) - 16;
         m_set = (m_rel >= 0) ? m_rel / 32 : -1;
         m_off = (m_rel >= 0) ? m_rel % 32 : -1;
         for (int s = 0; s < NS; s++) begin
            m_pin = pin_lvl[s*32 +: 32];
            m_hit = (m_pin & ~m_prev[s] & m_rise[s]) | (~m_pin & m_prev[s] & m_fall[s]);
            m_clr = (bus_we && m_set == s && m_off == 16) ? bus_wdata : 0;
            m_flag[s] = (m_flag[s] & ~m_clr) | m_hit;
            if (bus_we && m_set == s) begin
               if (m_off == 0)  m_rise[s] = m_rise[s] | bus_wdata;
               if (m_off == 4)  m_rise[s] = m_rise[s] & ~bus_wdata;
               if (m_off == 8)  m_fall[s] = m_fall[s] | bus_wdata;
               if (m_off == 12) m_fall[s] = m_fall[s] & ~bus_wdata;
            end
            m_prev[s] = m_pin;
         end
         if (bus_we && bus_addr == 8'h08) m_ben = bus_wdata[NB-1:0];
      end
   end

   function automatic logic [NB-1:0] model_irq();
      logic [NB-1:0] r;
      for (int b = 0; b < NB; b++)
         r[b] = m_ben[b] && ((m_flag[b/2] >> (16*(b%2))) & 32'hFFFF) != 0;
      return r;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R8 R7: every line against the model on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) chk("R8 irq vs model", 32'(irq_o), 32'(model_irq()));
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic wr_pins(logic [7:0] a, logic [31:0] d, logic [NP-1:0] p);
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d; pin_lvl = p;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic pins(logic [NP-1:0] p);
      @(negedge clk);
      pin_lvl = p;
   endtask

   task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic irq_is(string tag, logic [NB-1:0] exp);
      @(negedge clk);
      #1;
      chk(tag, 32'(irq_o), 32'(exp));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      pin_lvl = 64'h1;
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R9 reset state
      irq_is("R9 irq after reset", '0);
      rd("R9 rise arm", 8'h10, 0);
      rd("R9 fall arm", 8'h18, 0);
      rd("R9 flags", 8'h20, 0);
      rd("R9 bank en", 8'h08, 0);
      pins(64'h0);
      rd("R9 no flag from reset edge", 8'h20, 0);
      // R1 R10
      wr(8'h10, 32'h0000_00FF);
      rd("R1 rise arm", 8'h10, 32'h0000_00FF);
      rd("R10 rise-off reads arm", 8'h14, 32'h0000_00FF);
      wr(8'h10, 32'h0000_0100);
      rd("R1 zero bits keep arm", 8'h10, 32'h0000_01FF);
      wr(8'h18, 32'h0000_0F0F);
      rd("R10 fall-off reads arm", 8'h1C, 32'h0000_0F0F);
      rd("R10 unmapped reads zero", 8'h04, 0);
      // R3 R7: flags latch while gated
      pins(64'h0000_0FFF);
      rd("R3 rising flags", 8'h20, 32'h0000_01FF);
      irq_is("R7 gated line low", '0);
      wr(8'h08, 32'hF);
      irq_is("R7 enabled bank 0", 4'b0001);
      // R4
      wr(8'h20, 32'h0000_000F);
      rd("R4 partial clear", 8'h20, 32'h0000_01F0);
      irq_is("R8 still high", 4'b0001);
      pins(64'h0);
      rd("R3 falling adds", 8'h20, 32'h0000_0FFF);
      wr(8'h20, 32'hFFFF_FFFF);
      rd("R4 full clear", 8'h20, 0);
      irq_is("R8 drops after clear", '0);
      // R2
      wr(8'h14, 32'h0000_00F0);
      rd("R2 rise disarm", 8'h10, 32'h0000_010F);
      pins(64'h0000_00F0);
      rd("R2 disarmed pins no flag", 8'h20, 0);
      // R5
      wr_pins(8'h20, 32'h1, 64'h0000_00F1);
      rd("R5 edge beats clear", 8'h20, 32'h1);
      irq_is("R8 fires again", 4'b0001);
      wr(8'h20, 32'h1);
      // R6 bank mapping
      wr(8'h30, 32'h0001_0000);
      wr(8'h10, 32'h0002_0000);
      pins({32'h0001_0000, 32'h0002_00F1});
      rd("R6 set1 flags", 8'h40, 32'h0001_0000);
      rd("R6 set0 flags", 8'h20, 32'h0002_0000);
      irq_is("R6 odd banks", 4'b1010);
      wr(8'h08, 32'h2);
      rd("R7 bank en readback", 8'h08, 32'h2);
      irq_is("R7 bank 3 gated", 4'b0010);
      wr(8'h40, 32'h0001_0000);
      irq_is("R8 bank 1 holds", 4'b0010);
      wr(8'h20, 32'h0002_0000);
      irq_is("R8 all cleared", '0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule